// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block evaluates a set of sum-of-products functions over a parameterised input vector. A first plane forms product terms. Each term is the AND of the input literals chosen for it, and each literal can be the true input, the complemented input, or absent. A second plane ORs selected product terms into each output. In PLA mode that second plane is fully programmable, so a single product term can feed several outputs. In PAL mode the second plane is bypassed: each output takes a fixed, contiguous group of 2, 4, 8 or 16 product terms, and no term is shared.

The personality is loaded one bit per clock into a shadow register through a serial configuration port. A single-cycle commit pulse copies the shadow into the active personality. The outputs stay at zero from reset until the first commit, and they are also held at zero for every cycle in which a shift is in progress. The default size is 16 inputs, 48 product terms and 8 outputs, and each of the three is a parameter.

Top module: `prog_logic_array`

## Requirements
- R1: Each literal uses 2 bits: 2'b01 selects the true input, 2'b10 selects the complemented input, and 2'b00 leaves the input out. 2'b11 forces the product term to 0.
- R2: A product term whose literals are all 2'b00 evaluates to 1.
- R3: With pal_mode_i low, output o is the OR of every product term t whose OR-plane bit (t,o) is 1. One term may drive several outputs, and a term whose OR-plane bits are all 0 affects no output.
- R4: With pal_mode_i high, the OR plane is ignored. The group size is G = 2 << pal_grp_i (codes 0..3 give 2, 4, 8, 16), and output o is the OR of terms o*G to o*G+G-1. An output whose group would pass the last term is 0.
- R5: The configuration stream is N_TERM*N_IN*2 + N_TERM*N_OUT bits long and is sent LSB first. Literal (t,i) sits at bits t*2*N_IN+2*i+1:t*2*N_IN+2*i. OR-plane bit (t,o) sits at bit N_TERM*2*N_IN + t*N_OUT + o.
- R6: Shifting (cfg_shift_i high, with data taken from cfg_data_i) writes only the shadow register. The active personality is left unchanged, and out_o is 0 in every cycle in which cfg_shift_i is high.
- R7: out_o is 0 from reset until the first cfg_commit_i pulse. A commit copies the shadow into the active personality, and the outputs follow the new personality from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_i | input | N_IN | Logic inputs |
| pal_mode_i | input | 1 | 1 = fixed term groups, 0 = programmable OR plane |
| pal_grp_i | input | 2 | PAL group size code (size = 2 << code) |
| cfg_shift_i | input | 1 | Shift one configuration bit into the shadow register |
| cfg_data_i | input | 1 | Serial configuration bit |
| cfg_commit_i | input | 1 | Copy the shadow register into the active personality |
| out_o | output | N_OUT | Function outputs |

## Verification
The case that is hardest to reach is a shadow register that holds a complete new personality while the old one is still active. Reaching it takes about two thousand shift cycles. After those cycles, the outputs must still show the previous personality. To set this up, the bench loads a function-generator personality and commits it. It then shifts in a second personality that is built for PAL mode and has every OR-plane bit set. The outputs are checked partway through the shift, then again after the shift but before the commit, and finally after the commit. The same PAL personality is then evaluated with every group-size code, and once more in PLA mode. In PLA mode the all-ones OR plane must collapse every output to 1.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;

  function automatic logic lit_eval(input logic [1:0] code, input logic x);
    case (lit_e'(code))
      LIT_NONE: lit_eval = 1'b1;
      LIT_TRUE: lit_eval = x;
      LIT_COMP: lit_eval = ~x;
      default:  lit_eval = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned CFG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             data_i,
  input  logic             commit_i,
  output logic [CFG_W-1:0] active_o,
  output logic             valid_o
);

  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] active_q;
  logic             valid_q;

  // first bit shifted lands at bit 0 after a full load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (shift_i) shadow_q <= {data_i, shadow_q[CFG_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      valid_q  <= 1'b0;
    end else if (commit_i) begin
      active_q <= shadow_q;
      valid_q  <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign valid_o  = valid_q;

  // R6
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(shadow_q));

  // R6
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_q));

  // R7
  valid_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> valid_q);

  // R7
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(commit_i));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_TERM = 48,
  localparam int unsigned ROW_W = 2 * N_IN,
  localparam int unsigned AND_W = N_TERM * ROW_W
) (
  input  logic [N_IN-1:0]   in_i,
  input  logic [AND_W-1:0]  and_cfg_i,
  output logic [N_TERM-1:0] term_o
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_W-1:0] row;
    logic             prod;
    assign row = and_cfg_i[t*ROW_W +: ROW_W];

    always_comb begin
      prod = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        prod = prod & lit_eval(row[2*i +: 2], in_i[i]);
      end
    end

    assign term_o[t] = prod;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 48,
  parameter int unsigned N_OUT  = 8,
  localparam int unsigned OR_W  = N_TERM * N_OUT,
  localparam int unsigned N_GRP = 4
) (
  input  logic [N_TERM-1:0] term_i,
  input  logic [OR_W-1:0]   or_cfg_i,
  input  logic              pal_mode_i,
  input  logic [1:0]        pal_grp_i,
  output logic [N_OUT-1:0]  sum_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] col;
    logic [N_GRP-1:0]  pal_g;
    logic              pla_sum;

    always_comb begin
      for (int t = 0; t < N_TERM; t++) col[t] = or_cfg_i[t*N_OUT + o];
    end
    assign pla_sum = |(term_i & col);

    // one hardwired OR per group size; out-of-range groups tie to 0
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      localparam int unsigned GS = 2 << g;
      if ((o + 1) * GS <= N_TERM) begin : g_fit
        assign pal_g[g] = |term_i[o*GS +: GS];
      end else begin : g_none
        assign pal_g[g] = 1'b0;
      end
    end

    assign sum_o[o] = pal_mode_i ? pal_g[pal_grp_i] : pla_sum;
  end

endmodule

// File: rtl/prog_logic_array.sv
module prog_logic_array #(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_TERM = 48,
  parameter int unsigned N_OUT  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic             pal_mode_i,
  input  logic [1:0]       pal_grp_i,
  input  logic             cfg_shift_i,
  input  logic             cfg_data_i,
  input  logic             cfg_commit_i,
  output logic [N_OUT-1:0] out_o
);

  localparam int unsigned AND_W = N_TERM * 2 * N_IN;
  localparam int unsigned OR_W  = N_TERM * N_OUT;
  localparam int unsigned CFG_W = AND_W + OR_W;

  logic [CFG_W-1:0]  pers;
  logic              pers_valid;
  logic [N_TERM-1:0] terms;
  logic [N_OUT-1:0]  sums;

  pla_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (cfg_shift_i),
    .data_i   (cfg_data_i),
    .commit_i (cfg_commit_i),
    .active_o (pers),
    .valid_o  (pers_valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_i      (in_i),
    .and_cfg_i (pers[AND_W-1:0]),
    .term_o    (terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i     (terms),
    .or_cfg_i   (pers[CFG_W-1:AND_W]),
    .pal_mode_i (pal_mode_i),
    .pal_grp_i  (pal_grp_i),
    .sum_o      (sums)
  );

  assign out_o = (pers_valid && !cfg_shift_i) ? sums : '0;

endmodule

// File: tb/prog_logic_array_tb.sv
module prog_logic_array_tb;

  localparam int N_IN   = 16;
  localparam int N_TERM = 48;
  localparam int N_OUT  = 8;
  localparam int AND_W  = N_TERM * 2 * N_IN;
  localparam int CFG_W  = AND_W + N_TERM * N_OUT;

  localparam logic [1:0] LT = 2'b01, LC = 2'b10, LN = 2'b00, LK = 2'b11;

  // bit0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR, 5 XNOR; index = {c,b,a}
  localparam logic [7:0] PLA_EXP [8] = '{8'hAC, 8'h96, 8'h96, 8'hA6, 8'h96, 8'hA6, 8'hA6, 8'h93};
  localparam logic [7:0] PAL4_EXP [8] = '{8'h6C, 8'h56, 8'h56, 8'h66, 8'h56, 8'h66, 8'h66, 8'h53};

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_IN-1:0]  in_i = '0;
  logic             pal_mode_i = 1'b0;
  logic [1:0]       pal_grp_i = 2'd0;
  logic             cfg_shift_i = 1'b0;
  logic             cfg_data_i = 1'b0;
  logic             cfg_commit_i = 1'b0;
  logic [N_OUT-1:0] out_o;

  logic [CFG_W-1:0] pers;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_logic_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_i), .pal_mode_i(pal_mode_i),
    .pal_grp_i(pal_grp_i), .cfg_shift_i(cfg_shift_i), .cfg_data_i(cfg_data_i),
    .cfg_commit_i(cfg_commit_i), .out_o(out_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_lit(input int t, input int i, input logic [1:0] c);
    pers[t*2*N_IN + 2*i +: 2] = c;
  endtask

  task automatic term3(input int t, input logic [1:0] ca, input logic [1:0] cb, input logic [1:0] cc);
    set_lit(t, 0, ca); set_lit(t, 1, cb); set_lit(t, 2, cc);
  endtask

  task automatic set_or(input int t, input int o);
    pers[AND_W + t*N_OUT + o] = 1'b1;
  endtask

  task automatic apply(input int k, input logic [2:0] abc);
    @(negedge clk);
    in_i = {13'(k * 1237 + 911), abc};
    #1;
  endtask

  // shift full personality; check outputs held at 0 halfway (R6)
  task automatic load;
    for (int k = 0; k < CFG_W; k++) begin
      @(negedge clk);
      cfg_shift_i = 1'b1;
      cfg_data_i  = pers[k];
      if (k == CFG_W / 2) begin
        #1;
        check("R6 mid-shift hold", out_o, 8'h00);
      end
    end
    @(negedge clk);
    cfg_shift_i = 1'b0;
    cfg_data_i  = 1'b0;
  endtask

  task automatic commit;
    @(negedge clk);
    cfg_commit_i = 1'b1;
    @(negedge clk);
    cfg_commit_i = 1'b0;
  endtask

  function automatic logic [7:0] pal_ref(input logic [1:0] g, input logic [2:0] v);
    logic a, b, c;
    a = v[0]; b = v[1]; c = v[2];
    case (g)
      2'd0: pal_ref = {1'b0, ~a & ~b & ~c, ~c, ~a | ~b, c, a | b, 1'b0, a & b & c};
      2'd2: pal_ref = {4'b0000, 1'b1, 1'b1, ~a | ~b | ~c, a | b | c};
      2'd3: pal_ref = 8'b0000_0011;
      default: pal_ref = PAL4_EXP[v];
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: out=%h expected=finished", out_o);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    apply(3, 3'b111);
    check("R7 in reset", out_o, 8'h00);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    apply(5, 3'b011);
    check("R7 before first commit", out_o, 8'h00);

    // PLA function generator with shared terms (R1 R2 R3 R5)
    pers = '0;
    term3(0, LT, LT, LT); set_or(0, 0); set_or(0, 4);
    term3(1, LC, LC, LC); set_or(1, 3); set_or(1, 5);
    term3(2, LT, LN, LN); set_or(2, 1);
    term3(3, LN, LT, LN); set_or(3, 1);
    term3(4, LN, LN, LT); set_or(4, 1);
    term3(5, LC, LN, LN); set_or(5, 2);
    term3(6, LN, LC, LN); set_or(6, 2);
    term3(7, LN, LN, LC); set_or(7, 2);
    term3(8, LT, LC, LC); set_or(8, 4);
    term3(9, LC, LT, LC); set_or(9, 4);
    term3(10, LC, LC, LT); set_or(10, 4);
    term3(11, LT, LT, LC); set_or(11, 5);
    term3(12, LT, LC, LT); set_or(12, 5);
    term3(13, LC, LT, LT); set_or(13, 5);
    set_or(14, 7);                                  // all-absent term -> 1
    term3(15, LT, LN, LN); set_lit(15, 9, LK); set_or(15, 6);  // killed term
    load;
    apply(7, 3'b111);
    check("R7 loaded but not committed", out_o, 8'h00);
    commit;
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 8; v++) begin
        apply(v + 8 * r, 3'(v));
        check("R1 R2 R3 R5 PLA table", out_o, PLA_EXP[v]);
      end
    end

    // PAL personality: all OR bits set, unused terms killed
    pers = '0;
    for (int t = 0; t < N_TERM; t++) begin
      set_lit(t, 0, LK);
      for (int o = 0; o < N_OUT; o++) set_or(t, o);
    end
    term3(0, LT, LT, LT);
    term3(4, LT, LN, LN); term3(5, LN, LT, LN); term3(6, LN, LN, LT);
    term3(8, LC, LN, LN); term3(9, LN, LC, LN); term3(10, LN, LN, LC);
    term3(12, LC, LC, LC);
    term3(16, LT, LC, LC); term3(17, LC, LT, LC); term3(18, LC, LC, LT); term3(19, LT, LT, LT);
    term3(20, LC, LC, LC); term3(21, LT, LT, LC); term3(22, LT, LC, LT); term3(23, LC, LT, LT);
    term3(24, LN, LN, LN);
    load;
    apply(21, 3'b110);
    check("R6 shadow isolated", out_o, PLA_EXP[6]);
    commit;

    pal_mode_i = 1'b1;
    pal_grp_i  = 2'd1;
    for (int v = 0; v < 8; v++) begin
      apply(v + 40, 3'(v));
      check("R4 PAL group 4", out_o, PAL4_EXP[v]);
    end
    for (int g = 0; g < 4; g++) begin
      if (g == 1) continue;
      pal_grp_i = 2'(g);
      for (int v = 0; v < 8; v++) begin
        apply(v + 60 + 8 * g, 3'(v));
        check("R4 PAL group size", out_o, pal_ref(2'(g), 3'(v)));
      end
    end

    // same personality with the programmable OR plane: every output ORs all terms
    pal_mode_i = 1'b0;
    for (int v = 0; v < 8; v += 3) begin
      apply(v + 99, 3'(v));
      check("R3 all-ones OR plane", out_o, 8'hFF);
    end

    // reset clears the active personality
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R7 reset clears", out_o, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;
    apply(1, 3'b111);
    check("R7 after re-reset", out_o, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule